// File: doc/BRIEF.md
# I2C Target Byte-Boundary Clock Hold

This block is the part of an I2C target interface that owns the SCL pull-down. It tracks a transfer from the bus START, through the data bits of each byte, to the acknowledge slot. Once the acknowledge clock pulse has ended, it keeps SCL low until the local processing backend reports that it can move another byte. SCL is never held low between the bits of a byte. The target runs at bus rates up to 100 kHz without per-bit holds, and it also works at very slow rates, below 10 kHz. The block has no time limit of its own.

The raw SCL and SDA pins pass through a two-flop synchroniser. Edge, START and STOP events are decoded from the synchronised copies. The target shifter gives a one-cycle `byte_done` strobe after a byte has been moved. The backend gives a level-sensitive `be_ready`. The output `scl_pull` is an open-drain pull-down enable. A status output mirrors the hold, and a counter reports the length of the most recent hold in system clocks.

The controller has five states:

| State | Meaning |
|---|---|
| IDLE | No transfer is in progress. |
| XFER | Data bits are moving. |
| ACK_HI | Waiting for the acknowledge clock to rise. |
| ACK_LO | Waiting for the acknowledge clock to fall. |
| HOLD | SCL is held low. |

Its transitions are:

| From | Condition | To |
|---|---|---|
| IDLE | START | XFER |
| XFER | `byte_done` | ACK_HI |
| ACK_HI | SCL rise | ACK_LO |
| ACK_LO | SCL fall | HOLD |
| HOLD | `be_ready` | XFER |
| HOLD | START or STOP | IDLE (abort) |
| XFER, ACK_HI or ACK_LO | STOP | IDLE |
| XFER, ACK_HI or ACK_LO | START (repeated) | XFER |

Top module: `i2c_target_stretcher`

## Requirements
- R1: While reset is held and right after it, `scl_pull` and `stretching` are 0 and `last_stretch` is 0.
- R2: SCL and SDA are sampled through two flops. START is SDA falling while SCL is high. STOP is SDA rising while SCL is high. Both are judged on the synchronised lines.
- R3: While the eight data bits of a byte are clocked, `scl_pull` stays 0 for the whole byte.
- R4: `byte_done` is pulsed while SCL is low after the 8th bit. The acknowledge clock pulse that follows is not held. When SCL falls at the end of that pulse, `scl_pull` is still 0 after two clock edges and is 1 after the third edge.
- R5: Once asserted, `scl_pull` stays 1 for as long as `be_ready` is low. It drops at the first clock edge that samples `be_ready` high.
- R6: `be_ready` is level-sensitive. If it is already high when the hold starts, the hold lasts exactly one clock.
- R7: A `byte_done` strobe outside a transfer (after STOP) is ignored. No later SCL falling edge causes a hold.
- R8: A START or STOP seen during a hold ends the hold at once and returns the controller to IDLE. While in IDLE, `byte_done` has no effect.
- R9: One clock after a hold ends, `last_stretch` holds the number of clocks that `scl_pull` was 1, saturating at 2^CNT_W-1. It keeps that value until the next hold ends.
- R10: A hold ended by START or STOP also updates `last_stretch` with its length.
- R11: A hold has no time limit: it lasts indefinitely for a slow backend.
- R12: Within one transfer, every byte gets its own hold, and each hold updates `last_stretch` with its own length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL pin level |
| sda_in | input | 1 | Raw SDA pin level |
| byte_done | input | 1 | One-cycle strobe from the shifter after the 8th bit |
| be_ready | input | 1 | Backend ready level; releases the hold |
| scl_pull | output | 1 | Open-drain pull-down enable for SCL |
| stretching | output | 1 | High while a hold is active |
| last_stretch | output | CNT_W | Length in clocks of the most recent hold |

## Verification
The bench counts clock edges after the acknowledge falling edge. A design whose synchroniser depth or edge detect is off by one asserts the pull on the wrong edge. One that holds on the 8th data bit shows the pull during the data phase.

Other tests target the release rules. A ready level that is already high must give a one-clock hold; a design that waits for a ready edge would hang. An abort by START or STOP must release the line. Holds are also counted under saturation, and a meter that counts one cycle too many or too few shows a wrong `last_stretch`. A stray `byte_done` while idle is checked to cause no hold.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_ACK_HI,
        ST_ACK_LO,
        ST_HOLD
    } hold_state_t;

endpackage

// File: rtl/i2cs_sync.sv
module i2cs_sync #(
    parameter int WIDTH   = 2,
    parameter int STAGES  = 2,
    parameter logic RST_LVL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= {WIDTH{RST_LVL}};
                end else if (g == 0) begin
                    stage_q[g] <= d_async;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign d_sync = stage_q[STAGES-1];

    initial begin
        a_r2_two_or_more_stages: assert (STAGES >= 2)
            else $error("synchroniser needs at least two stages");
    end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_d;
    logic sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = scl_d & ~scl_s;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end

    a_r2_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({scl_rise, scl_fall, start_det, stop_det}) <= 1);
endmodule

// File: rtl/i2cs_hold_fsm.sv
module i2cs_hold_fsm
    import i2cs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic scl_rise,
    input  logic scl_fall,
    input  logic start_det,
    input  logic stop_det,
    input  logic byte_done,
    input  logic be_ready,
    output logic scl_pull,
    output logic hold_active
);
    hold_state_t state_q;
    hold_state_t state_n;
    logic        bus_evt;

    assign bus_evt = start_det | stop_det;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_det) state_n = ST_XFER;
            end
            ST_XFER: begin
                if (stop_det)       state_n = ST_IDLE;
                else if (start_det) state_n = ST_XFER;
                else if (byte_done) state_n = ST_ACK_HI;
            end
            ST_ACK_HI: begin
                if (stop_det)       state_n = ST_IDLE;
                else if (start_det) state_n = ST_XFER;
                else if (scl_rise)  state_n = ST_ACK_LO;
            end
            ST_ACK_LO: begin
                if (stop_det)       state_n = ST_IDLE;
                else if (start_det) state_n = ST_XFER;
                else if (scl_fall)  state_n = ST_HOLD;
            end
            ST_HOLD: begin
                if (bus_evt)       state_n = ST_IDLE;
                else if (be_ready) state_n = ST_XFER;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        scl_pull    = (state_q == ST_HOLD);
        hold_active = (state_q == ST_HOLD);
    end

    a_r4_pull_follows_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_pull) |-> $past(scl_fall));
    a_r3_no_pull_from_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |=> !scl_pull);
    a_r5_release_on_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull && be_ready) |=> !scl_pull);
    a_r11_hold_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull && !be_ready && !bus_evt) |=> scl_pull);
    a_r8_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_pull && bus_evt) |=> (state_q == ST_IDLE));
    a_r7_idle_ignores_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start_det) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/i2cs_stretch_meter.sv
module i2cs_stretch_meter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    output logic [CNT_W-1:0] last_len
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] run_q;
    logic             hold_q;
    logic             hold_end;

    assign hold_end = hold_q & ~hold;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q    <= '0;
            hold_q   <= 1'b0;
            last_len <= '0;
        end else begin
            hold_q <= hold;
            if (!hold) begin
                run_q <= '0;
            end else if (run_q != CNT_MAX) begin
                run_q <= run_q + 1'b1;
            end
            if (hold_end) begin
                last_len <= run_q;
            end
        end
    end

    a_r9_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(hold) |=> (last_len != '0));
    a_r9_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(hold) |=> $stable(last_len));
endmodule

// File: rtl/i2c_target_stretcher.sv
module i2c_target_stretcher #(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic             byte_done,
    input  logic             be_ready,
    output logic             scl_pull,
    output logic             stretching,
    output logic [CNT_W-1:0] last_stretch
);
    logic [1:0] lines_s;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;

    i2cs_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_LVL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({sda_in, scl_in}),
        .d_sync  (lines_s)
    );

    i2cs_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (lines_s[0]),
        .sda_s     (lines_s[1]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cs_hold_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .byte_done   (byte_done),
        .be_ready    (be_ready),
        .scl_pull    (scl_pull),
        .hold_active (stretching)
    );

    i2cs_stretch_meter #(
        .CNT_W (CNT_W)
    ) u_meter (
        .clk      (clk),
        .rst_n    (rst_n),
        .hold     (stretching),
        .last_len (last_stretch)
    );

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (!scl_pull && last_stretch == '0));
endmodule

// File: tb/i2c_target_stretcher_test.sv
module i2c_target_stretcher_test;
    localparam int CW = 6;
    localparam int H  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          scl_m = 1'b1;
    logic          sda_m = 1'b1;
    logic          honor = 1'b1;
    logic          byte_done = 1'b0;
    logic          be_ready = 1'b0;
    logic          scl_in;
    logic          sda_in;
    logic          scl_pull;
    logic          stretching;
    logic [CW-1:0] last_stretch;

    int n_checks = 0;
    int n_fail   = 0;
    int pull_cnt = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    assign scl_in = scl_m & ~(scl_pull & honor);
    assign sda_in = sda_m;

    i2c_target_stretcher #(.SYNC_STAGES(2), .CNT_W(CW)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_in),
        .sda_in       (sda_in),
        .byte_done    (byte_done),
        .be_ready     (be_ready),
        .scl_pull     (scl_pull),
        .stretching   (stretching),
        .last_stretch (last_stretch)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk);
            if (scl_pull) pull_cnt++;
        end
    endtask

    task automatic clk_high();
        scl_m = 1'b1;
        tick(1);
        while (!scl_in) tick(1);
        tick(H);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(H);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; sda_m = 1'b0; tick(H);
        clk_high();
        sda_m = 1'b1; tick(H);
    endtask

    // clocks a byte and its ack; returns just after the negedge where the pull is first seen
    task automatic send_byte(input logic [7:0] d, input bit early_ready);
        pull_cnt = 0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = d[i]; tick(H);
            clk_high();
            scl_m = 1'b0; tick(H);
        end
        check("R3 no hold inside byte", pull_cnt, 0);
        byte_done = 1'b1; tick(1); byte_done = 1'b0;
        sda_m = 1'b0;
        if (early_ready) be_ready = 1'b1;
        tick(H);
        scl_m = 1'b1; tick(H);
        check("R4 ack pulse not held", int'(scl_in), 1);
        scl_m = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R4 pull low after two edges", int'(scl_pull), 0);
        @(posedge clk); @(negedge clk);
        check("R4 pull high after third edge", int'(scl_pull), 1);
    endtask

    task automatic release_after(input int d, input int exp_len, input string req);
        pull_cnt = 0;
        tick(d);
        check({req, " held while not ready"}, pull_cnt, d);
        be_ready = 1'b1;
        @(negedge clk);
        check("R5 released on ready", int'(scl_pull), 0);
        check("R5 status cleared", int'(stretching), 0);
        be_ready = 1'b0;
        @(negedge clk);
        check({req, " last length"}, int'(last_stretch), exp_len);
    endtask

    task automatic t_reset();
        check("R1 pull in reset", int'(scl_pull), 0);
        rst_n = 1'b1;
        tick(3);
        check("R1 pull after reset", int'(scl_pull), 0);
        check("R1 status after reset", int'(stretching), 0);
        check("R1 length after reset", int'(last_stretch), 0);
    endtask

    task automatic t_two_bytes();
        bus_start();
        send_byte(8'hA5, 1'b0);
        check("R2 status mirrors hold", int'(stretching), 1);
        release_after(5, 6, "R9");
        send_byte(8'h3C, 1'b0);
        release_after(20, 21, "R12");
        bus_stop();
    endtask

    task automatic t_early_ready();
        bus_start();
        send_byte(8'h81, 1'b1);
        @(negedge clk);
        check("R6 one-clock hold", int'(scl_pull), 0);
        be_ready = 1'b0;
        @(negedge clk);
        check("R6 length one", int'(last_stretch), 1);
        bus_stop();
    endtask

    task automatic t_long_hold();
        bus_start();
        send_byte(8'h0F, 1'b0);
        release_after(1500, 63, "R11");
        check("R9 saturated length", int'(last_stretch), 63);
        bus_stop();
    endtask

    task automatic t_idle_ignored();
        tick(H);
        byte_done = 1'b1; tick(1); byte_done = 1'b0;
        scl_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        pull_cnt = 0;
        scl_m = 1'b0; tick(12);
        check("R7 idle strobe ignored", pull_cnt, 0);
        scl_m = 1'b1; tick(H);
    endtask

    task automatic t_abort(input bit by_stop);
        bus_start();
        send_byte(8'h5A, 1'b0);
        honor = 1'b0;
        pull_cnt = 0;
        sda_m = by_stop ? 1'b0 : 1'b1;
        tick(3);
        scl_m = 1'b1; tick(4);
        sda_m = by_stop ? 1'b1 : 1'b0;
        tick(8);
        check(by_stop ? "R8 stop ends hold" : "R8 start ends hold", int'(scl_pull), 0);
        check("R10 aborted length", int'(last_stretch), pull_cnt + 1);
        honor = 1'b1;
        if (!by_stop) begin
            pull_cnt = 0;
            scl_m = 1'b0; tick(H);
            byte_done = 1'b1; tick(1); byte_done = 1'b0;
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0; tick(10);
            check("R8 idle after start abort", pull_cnt, 0);
            bus_stop();
        end
    endtask

    initial begin
        tick(4);
        t_reset();
        t_two_bytes();
        t_early_ready();
        t_long_hold();
        t_idle_ignored();
        t_abort(1'b1);
        t_abort(1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule